// File: doc/BRIEF.md
# Directory DMA write controller

This block is a small directory for a set of memory lines. For each line it keeps a coherence state, a vector of sharing caches and the identity of the owning cache. Its job is to serve DMA write requests that arrive alongside cache coherence traffic. A write that covers a whole line is sent straight to memory. A shorter write cannot be sent that way. The block first reads the line from memory, or gets the dirty copy from the owning cache. It then overlays the DMA bytes on that line and writes the full result back.

One transaction buffer holds the pending partial or owner-bound write: line, byte offset, length, requestor id and data. A request that cannot be served at once is not dropped. The block raises a retry indication so the sender can present it again later. This happens when the line is in a transient state, when the buffer is busy, or when another event takes the same cycle.

Cache unblocks drive the line states. They add a sharer, hand ownership to a cache, return the owner's data, or report that the DMA engine has finished with a line. Memory returns fetched data and writeback acknowledgements.

Top module: `dma_dir_ctrl`

## Requirements
- R1: After reset every line is Invalid with no sharers and the buffer is free. No output valid is raised until an input event arrives.
- R2: A write is full-line when `req_len` equals the line size in bytes, with `req_off` zero. A full-line write to an Invalid or Shared line does three things one cycle later. It issues a memory write (`mem_req_write`=1) of `req_data`. It acknowledges the DMA with `req_id` and the count of current sharers. If the line was Shared, it also sends an invalidation with the sharer mask. The line then waits for the DMA engine.
- R3: A partial write to an Invalid or Shared line takes the buffer. One cycle later it issues a memory read (`mem_req_write`=0) of that line, plus an invalidation if the line was Shared. No acknowledgement is sent yet.
- R4: A fetched-data response (`mem_rsp_wback`=0, `mem_rsp_dma`=1) for the buffered line arrives while that line waits for it. One cycle later the block writes back a full line in which bytes `off` to `off+len-1` come from the DMA data and all other bytes come from the fetched data. Byte b is bits 8b+7..8b. In the same cycle it acknowledges the buffered requestor with the sharer count. It frees the buffer, and the line then waits for the DMA engine. Fetched data in any other situation produces no output.
- R5: Any DMA write to an Owned or Modified line takes the buffer. One cycle later it asks the owner for its data (`fwd_valid`, `fwd_owner`, `fwd_line`) and invalidates any other sharers. It does not touch memory.
- R6: Owner data (`ub_kind`=3) for the buffered line arrives while that line waits for it. The block merges it with the buffered DMA bytes as in R4, writes the result to memory, acknowledges the DMA and frees the buffer.
- R7: A request to a line in any transient state is not served and `req_retry` is raised one cycle later, with no other output.
- R8: While the buffer is busy, a partial write, or any write to an Owned or Modified line, is retried.
- R9: A writeback acknowledgement (`mem_rsp_wback`=1) produces no output and changes no line state.
- R10: Unblock kind 0 adds `ub_src` as a sharer. The line becomes Shared if it was Invalid or Shared, and Owned if it was Modified or Owned. Kind 1 makes `ub_src` the owner of an Invalid or Shared line, moving it to Modified and clearing its sharers. Kind 2 returns a line that waits for the DMA engine to Invalid and clears its sharers.
- R11: Events take priority in this order: memory response, then unblock, then request. A request presented in the same cycle as either of the others is retried. An unblock presented together with a memory response is not processed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | DMA write request present |
| req_line | input | LINE_W | Target line index |
| req_off | input | OFF_W | First byte written |
| req_len | input | LEN_W | Number of bytes written |
| req_id | input | ID_W | Requestor id returned in the ack |
| req_data | input | 8*LINE_BYTES | Write data, byte b in lane b |
| req_retry | output | 1 | Request was not served, present again later |
| mem_req_valid | output | 1 | Memory request |
| mem_req_write | output | 1 | 1 write, 0 read |
| mem_req_line | output | LINE_W | Memory request line |
| mem_req_data | output | 8*LINE_BYTES | Full-line write data |
| mem_rsp_valid | input | 1 | Memory response present |
| mem_rsp_wback | input | 1 | 1 writeback ack, 0 fetched data |
| mem_rsp_dma | input | 1 | Fetched data was requested for a DMA write |
| mem_rsp_line | input | LINE_W | Response line |
| mem_rsp_data | input | 8*LINE_BYTES | Fetched line |
| dma_ack_valid | output | 1 | DMA write complete |
| dma_ack_id | output | ID_W | Requestor being acknowledged |
| dma_ack_count | output | CNT_W | Number of sharers to collect acks from |
| inv_valid | output | 1 | Invalidation to sharers |
| inv_mask | output | NCACHES | Caches to invalidate |
| fwd_valid | output | 1 | Data request to the owner |
| fwd_owner | output | CID_W | Owning cache |
| fwd_line | output | LINE_W | Line requested |
| ub_valid | input | 1 | Unblock present |
| ub_kind | input | 2 | 0 share, 1 take ownership, 2 DMA done, 3 owner data |
| ub_src | input | CID_W | Sending cache |
| ub_line | input | LINE_W | Unblock line |
| ub_data | input | 8*LINE_BYTES | Owner data for kind 3 |

## Verification
Every result appears on the registered outputs exactly one clock after the input that caused it. This covers the memory write, acknowledgement, read, forward, invalidation and retry. The bench drives inputs just after a falling edge and advances a reference model on the same inputs. At the next falling edge it compares every output group with the model, so each check falls in the single cycle a result is due. The merged lines for a first-byte, a middle and a last-byte partial write are also compared with hand-computed constants in that cycle.

// File: rtl/dma_dir_pkg.sv
package dma_dir_pkg;
  typedef enum logic [2:0] {
    LN_INV, LN_SHR, LN_OWN, LN_MOD,
    LN_DMA_WAIT, LN_FETCH, LN_OWNER_WAIT
  } line_st_t;

  typedef enum logic [1:0] {
    UB_SHARE = 2'd0, UB_TAKE = 2'd1, UB_DMA_DONE = 2'd2, UB_OWNER_DATA = 2'd3
  } ub_kind_t;
endpackage

// File: rtl/dma_dir_merge.sv
module dma_dir_merge #(
  parameter int LINE_BYTES = 8,
  parameter int OFF_W = 3,
  parameter int LEN_W = 4
) (
  input  logic [8*LINE_BYTES-1:0] base,
  input  logic [8*LINE_BYTES-1:0] patch,
  input  logic [OFF_W-1:0]        off,
  input  logic [LEN_W-1:0]        len,
  output logic [8*LINE_BYTES-1:0] merged
);
  localparam int SW = LEN_W + 1;
  logic [SW-1:0] lo, hi;
  assign lo = SW'(off);
  assign hi = lo + SW'(len);

  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
    assign merged[8*b +: 8] = (SW'(b) >= lo && SW'(b) < hi) ? patch[8*b +: 8]
                                                            : base[8*b +: 8];
  end
endmodule

// File: rtl/dma_dir_tbuf.sv
module dma_dir_tbuf #(
  parameter int LINE_BYTES = 8,
  parameter int LINE_W = 2,
  parameter int OFF_W = 3,
  parameter int LEN_W = 4,
  parameter int ID_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    alloc,
  input  logic                    free,
  input  logic [LINE_W-1:0]       in_line,
  input  logic [OFF_W-1:0]        in_off,
  input  logic [LEN_W-1:0]        in_len,
  input  logic [ID_W-1:0]         in_id,
  input  logic [8*LINE_BYTES-1:0] in_data,
  output logic                    busy,
  output logic [LINE_W-1:0]       line,
  output logic [OFF_W-1:0]        off,
  output logic [LEN_W-1:0]        len,
  output logic [ID_W-1:0]         id,
  output logic [8*LINE_BYTES-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) busy <= 1'b0;
    else if (alloc) busy <= 1'b1;
    else if (free) busy <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (alloc) begin
      line <= in_line;
      off  <= in_off;
      len  <= in_len;
      id   <= in_id;
      data <= in_data;
    end
  end
endmodule

// File: rtl/dma_dir_ctrl.sv
module dma_dir_ctrl
  import dma_dir_pkg::*;
#(
  parameter int NLINES = 4,
  parameter int NCACHES = 4,
  parameter int LINE_BYTES = 8,
  parameter int ID_W = 4,
  localparam int LINE_W = $clog2(NLINES),
  localparam int CID_W = $clog2(NCACHES),
  localparam int OFF_W = $clog2(LINE_BYTES),
  localparam int LEN_W = $clog2(LINE_BYTES + 1),
  localparam int CNT_W = $clog2(NCACHES + 1),
  localparam int DW = 8 * LINE_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [LINE_W-1:0] req_line,
  input  logic [OFF_W-1:0]  req_off,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [ID_W-1:0]   req_id,
  input  logic [DW-1:0]     req_data,
  output logic              req_retry,
  output logic              mem_req_valid,
  output logic              mem_req_write,
  output logic [LINE_W-1:0] mem_req_line,
  output logic [DW-1:0]     mem_req_data,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_wback,
  input  logic              mem_rsp_dma,
  input  logic [LINE_W-1:0] mem_rsp_line,
  input  logic [DW-1:0]     mem_rsp_data,
  output logic              dma_ack_valid,
  output logic [ID_W-1:0]   dma_ack_id,
  output logic [CNT_W-1:0]  dma_ack_count,
  output logic              inv_valid,
  output logic [NCACHES-1:0] inv_mask,
  output logic              fwd_valid,
  output logic [CID_W-1:0]  fwd_owner,
  output logic [LINE_W-1:0] fwd_line,
  input  logic              ub_valid,
  input  logic [1:0]        ub_kind,
  input  logic [CID_W-1:0]  ub_src,
  input  logic [LINE_W-1:0] ub_line,
  input  logic [DW-1:0]     ub_data
);
  function automatic logic [CNT_W-1:0] ones(input logic [NCACHES-1:0] v);
    logic [CNT_W-1:0] n = '0;
    for (int i = 0; i < NCACHES; i++) n = n + CNT_W'(v[i]);
    return n;
  endfunction

  line_st_t          st_q  [NLINES];
  logic [NCACHES-1:0] shr_q [NLINES];
  logic [CID_W-1:0]  own_q [NLINES];

  logic              tb_busy;
  logic [LINE_W-1:0] tb_line;
  logic [OFF_W-1:0]  tb_off;
  logic [LEN_W-1:0]  tb_len;
  logic [ID_W-1:0]   tb_id;
  logic [DW-1:0]     tb_data;

  logic evt_mem, evt_ub, evt_req, req_full, req_clean, req_dirty;
  logic req_take_full, tb_alloc, tb_free, mem_merge, ub_merge, retry_d;
  line_st_t req_st, ub_st;
  logic [DW-1:0] mrg_base, mrg_line;

  always_comb begin
    evt_mem   = mem_rsp_valid;
    evt_ub    = ub_valid && !mem_rsp_valid;
    evt_req   = req_valid && !mem_rsp_valid && !ub_valid;
    req_st    = st_q[req_line];
    ub_st     = st_q[ub_line];
    req_full  = (req_len == LEN_W'(LINE_BYTES));
    req_clean = (req_st == LN_INV) || (req_st == LN_SHR);
    req_dirty = (req_st == LN_OWN) || (req_st == LN_MOD);
    req_take_full = evt_req && req_clean && req_full;
    tb_alloc  = evt_req && !tb_busy && ((req_clean && !req_full) || req_dirty);
    retry_d   = req_valid && !(req_take_full || tb_alloc);
    mem_merge = evt_mem && !mem_rsp_wback && mem_rsp_dma && tb_busy &&
                mem_rsp_line == tb_line && st_q[tb_line] == LN_FETCH;
    ub_merge  = evt_ub && ub_kind == UB_OWNER_DATA && tb_busy &&
                ub_line == tb_line && st_q[tb_line] == LN_OWNER_WAIT;
    tb_free   = mem_merge || ub_merge;
    mrg_base  = evt_mem ? mem_rsp_data : ub_data;
  end

  dma_dir_tbuf #(.LINE_BYTES(LINE_BYTES), .LINE_W(LINE_W), .OFF_W(OFF_W),
                 .LEN_W(LEN_W), .ID_W(ID_W)) u_tbuf (
    .clk(clk), .rst(rst), .alloc(tb_alloc), .free(tb_free),
    .in_line(req_line), .in_off(req_off), .in_len(req_len), .in_id(req_id),
    .in_data(req_data), .busy(tb_busy), .line(tb_line), .off(tb_off),
    .len(tb_len), .id(tb_id), .data(tb_data));

  dma_dir_merge #(.LINE_BYTES(LINE_BYTES), .OFF_W(OFF_W), .LEN_W(LEN_W)) u_merge (
    .base(mrg_base), .patch(tb_data), .off(tb_off), .len(tb_len),
    .merged(mrg_line));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NLINES; i++) begin
        st_q[i]  <= LN_INV;
        shr_q[i] <= '0;
        own_q[i] <= '0;
      end
      req_retry     <= 1'b0;
      mem_req_valid <= 1'b0;
      mem_req_write <= 1'b0;
      mem_req_line  <= '0;
      mem_req_data  <= '0;
      dma_ack_valid <= 1'b0;
      dma_ack_id    <= '0;
      dma_ack_count <= '0;
      inv_valid     <= 1'b0;
      inv_mask      <= '0;
      fwd_valid     <= 1'b0;
      fwd_owner     <= '0;
      fwd_line      <= '0;
    end else begin
      req_retry     <= retry_d;
      mem_req_valid <= 1'b0;
      dma_ack_valid <= 1'b0;
      inv_valid     <= 1'b0;
      fwd_valid     <= 1'b0;
      if (tb_free) begin
        mem_req_valid <= 1'b1;
        mem_req_write <= 1'b1;
        mem_req_line  <= tb_line;
        mem_req_data  <= mrg_line;
        dma_ack_valid <= 1'b1;
        dma_ack_id    <= tb_id;
        dma_ack_count <= ones(shr_q[tb_line]);
        st_q[tb_line] <= LN_DMA_WAIT;
      end else if (evt_ub) begin
        case (ub_kind)
          UB_SHARE: begin
            if (ub_st == LN_INV || ub_st == LN_SHR) begin
              shr_q[ub_line][ub_src] <= 1'b1;
              st_q[ub_line] <= LN_SHR;
            end else if (ub_st == LN_MOD || ub_st == LN_OWN) begin
              shr_q[ub_line][ub_src] <= 1'b1;
              st_q[ub_line] <= LN_OWN;
            end
          end
          UB_TAKE: begin
            if (ub_st == LN_INV || ub_st == LN_SHR) begin
              st_q[ub_line]  <= LN_MOD;
              own_q[ub_line] <= ub_src;
              shr_q[ub_line] <= '0;
            end
          end
          UB_DMA_DONE: begin
            if (ub_st == LN_DMA_WAIT) begin
              st_q[ub_line]  <= LN_INV;
              shr_q[ub_line] <= '0;
            end
          end
          default: ;
        endcase
      end else if (req_take_full || tb_alloc) begin
        inv_valid <= (req_st != LN_INV) && (shr_q[req_line] != '0);
        inv_mask  <= shr_q[req_line];
        if (req_dirty) begin
          fwd_valid      <= 1'b1;
          fwd_owner      <= own_q[req_line];
          fwd_line       <= req_line;
          st_q[req_line] <= LN_OWNER_WAIT;
        end else begin
          mem_req_valid <= 1'b1;
          mem_req_line  <= req_line;
          if (req_full) begin
            mem_req_write  <= 1'b1;
            mem_req_data   <= req_data;
            dma_ack_valid  <= 1'b1;
            dma_ack_id     <= req_id;
            dma_ack_count  <= ones(shr_q[req_line]);
            st_q[req_line] <= LN_DMA_WAIT;
          end else begin
            mem_req_write  <= 1'b0;
            mem_req_data   <= '0;
            st_q[req_line] <= LN_FETCH;
          end
        end
      end
    end
  end
endmodule

// File: rtl/dma_dir_chk.sv
module dma_dir_chk #(
  parameter int NCACHES = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               mem_rsp_valid,
  input logic               mem_rsp_wback,
  input logic               ub_valid,
  input logic               req_retry,
  input logic               mem_req_valid,
  input logic               mem_req_write,
  input logic               dma_ack_valid,
  input logic               fwd_valid,
  input logic               inv_valid,
  input logic [NCACHES-1:0] inv_mask
);
  // R11
  collide_retry_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && (mem_rsp_valid || ub_valid) |=> req_retry);

  // R2
  ack_with_write_chk: assert property (@(posedge clk) disable iff (rst)
    dma_ack_valid |-> mem_req_valid && mem_req_write);

  // R5
  fwd_no_mem_chk: assert property (@(posedge clk) disable iff (rst)
    fwd_valid |-> !mem_req_valid && !dma_ack_valid);

  // R3
  inv_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    inv_valid |-> inv_mask != '0);

  // R9
  wback_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rsp_valid && mem_rsp_wback |=> !mem_req_valid && !dma_ack_valid && !fwd_valid);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid && !mem_rsp_valid && !ub_valid |=>
      !mem_req_valid && !dma_ack_valid && !fwd_valid && !inv_valid && !req_retry);
endmodule

bind dma_dir_ctrl dma_dir_chk #(.NCACHES(NCACHES)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .mem_rsp_valid(mem_rsp_valid),
  .mem_rsp_wback(mem_rsp_wback), .ub_valid(ub_valid), .req_retry(req_retry),
  .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
  .dma_ack_valid(dma_ack_valid), .fwd_valid(fwd_valid), .inv_valid(inv_valid),
  .inv_mask(inv_mask));

// File: tb/sim_dma_dir_ctrl.sv
`timescale 1ns/1ps
module sim_dma_dir_ctrl;
  logic clk = 0, rst = 1;
  always #4 clk = ~clk;

  logic req_valid = 0; logic [1:0] req_line = 0; logic [2:0] req_off = 0;
  logic [3:0] req_len = 0; logic [3:0] req_id = 0; logic [63:0] req_data = 0;
  logic req_retry, mem_req_valid, mem_req_write; logic [1:0] mem_req_line;
  logic [63:0] mem_req_data;
  logic mem_rsp_valid = 0, mem_rsp_wback = 0, mem_rsp_dma = 0;
  logic [1:0] mem_rsp_line = 0; logic [63:0] mem_rsp_data = 0;
  logic dma_ack_valid; logic [3:0] dma_ack_id; logic [2:0] dma_ack_count;
  logic inv_valid; logic [3:0] inv_mask; logic fwd_valid; logic [1:0] fwd_owner, fwd_line;
  logic ub_valid = 0; logic [1:0] ub_kind = 0, ub_src = 0, ub_line = 0;
  logic [63:0] ub_data = 0;

  dma_dir_ctrl u0 (.*);

  int checks = 0, failures = 0;
  string cur = "R1";
  bit done = 0;

  // reference model: 0 I,1 S,2 O,3 M,4 wait-dma,5 fetch,6 wait-owner
  int ms[4]; bit [3:0] msh[4]; int mown[4];
  bit tbb; int tbl, tbo, tbn, tbi; logic [63:0] tbd;
  bit e_retry, e_mv, e_mw, e_av, e_iv, e_fv;
  int e_ml, e_ai, e_ac, e_fo, e_fl; logic [63:0] e_md; bit [3:0] e_im;

  function automatic logic [63:0] mix(input logic [63:0] base);
    logic [63:0] r = base;
    for (int b = tbo; b < tbo + tbn; b++) r[8*b +: 8] = tbd[8*b +: 8];
    return r;
  endfunction

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", cur, what, act, exp);
    end
  endtask

  task automatic model_step();
    e_retry = 0; e_mv = 0; e_av = 0; e_iv = 0; e_fv = 0;
    if (mem_rsp_valid) begin
      if (req_valid) e_retry = 1;
      if (!mem_rsp_wback && mem_rsp_dma && tbb && mem_rsp_line == tbl && ms[tbl] == 5) begin
        e_mv = 1; e_mw = 1; e_ml = tbl; e_md = mix(mem_rsp_data);
        e_av = 1; e_ai = tbi; e_ac = $countones(msh[tbl]); ms[tbl] = 4; tbb = 0;
      end
    end else if (ub_valid) begin
      if (req_valid) e_retry = 1;
      if (ub_kind == 3 && tbb && ub_line == tbl && ms[tbl] == 6) begin
        e_mv = 1; e_mw = 1; e_ml = tbl; e_md = mix(ub_data);
        e_av = 1; e_ai = tbi; e_ac = $countones(msh[tbl]); ms[tbl] = 4; tbb = 0;
      end else if (ub_kind == 0 && ms[ub_line] <= 3) begin
        msh[ub_line][ub_src] = 1; ms[ub_line] = (ms[ub_line] <= 1) ? 1 : 2;
      end else if (ub_kind == 1 && ms[ub_line] <= 1) begin
        ms[ub_line] = 3; mown[ub_line] = ub_src; msh[ub_line] = 0;
      end else if (ub_kind == 2 && ms[ub_line] == 4) begin
        ms[ub_line] = 0; msh[ub_line] = 0;
      end
    end else if (req_valid) begin
      int s = ms[req_line];
      bit full = (req_len == 8);
      if (s <= 1 && full) begin
        e_iv = (s == 1 && msh[req_line] != 0); e_im = msh[req_line];
        e_mv = 1; e_mw = 1; e_ml = req_line; e_md = req_data;
        e_av = 1; e_ai = req_id; e_ac = $countones(msh[req_line]); ms[req_line] = 4;
      end else if (!tbb && s <= 3) begin
        tbb = 1; tbl = req_line; tbo = req_off; tbn = req_len; tbi = req_id; tbd = req_data;
        e_iv = (s != 0 && msh[req_line] != 0); e_im = msh[req_line];
        if (s <= 1) begin e_mv = 1; e_mw = 0; e_ml = req_line; ms[req_line] = 5; end
        else begin e_fv = 1; e_fo = mown[req_line]; e_fl = req_line; ms[req_line] = 6; end
      end else e_retry = 1;
    end
  endtask

  task automatic tick();
    model_step();
    @(posedge clk); @(negedge clk);
    chk(req_retry == e_retry, "retry", 64'(req_retry), 64'(e_retry));
    chk(mem_req_valid == e_mv && (!e_mv || (mem_req_write == e_mw && mem_req_line == 2'(e_ml) &&
        (!e_mw || mem_req_data == e_md))), "mem_req", mem_req_data, e_md);
    chk(dma_ack_valid == e_av && (!e_av || (dma_ack_id == 4'(e_ai) && dma_ack_count == 3'(e_ac))),
        "dma_ack", {dma_ack_valid, dma_ack_id, dma_ack_count}, {e_av, 4'(e_ai), 3'(e_ac)});
    chk(inv_valid == e_iv && (!e_iv || inv_mask == e_im), "inv", {inv_valid, inv_mask}, {e_iv, e_im});
    chk(fwd_valid == e_fv && (!e_fv || (fwd_owner == 2'(e_fo) && fwd_line == 2'(e_fl))),
        "fwd", {fwd_valid, fwd_owner, fwd_line}, {e_fv, 2'(e_fo), 2'(e_fl)});
    req_valid = 0; mem_rsp_valid = 0; ub_valid = 0;
  endtask

  task automatic do_req(input int ln, input int off, input int len, input int id, input logic [63:0] d);
    req_valid = 1; req_line = 2'(ln); req_off = 3'(off); req_len = 4'(len); req_id = 4'(id); req_data = d;
  endtask
  task automatic do_ub(input int k, input int src, input int ln, input logic [63:0] d);
    ub_valid = 1; ub_kind = 2'(k); ub_src = 2'(src); ub_line = 2'(ln); ub_data = d;
  endtask
  task automatic do_mem(input bit wb, input int ln, input logic [63:0] d);
    mem_rsp_valid = 1; mem_rsp_wback = wb; mem_rsp_dma = 1; mem_rsp_line = 2'(ln); mem_rsp_data = d;
  endtask

  localparam logic [63:0] FETCH = 64'hAAAA_AAAA_AAAA_AAAA;
  localparam logic [63:0] PAT   = 64'h0011_2233_4455_6677;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin ms[i] = 0; msh[i] = 0; mown[i] = 0; end
    tbb = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    cur = "R1"; tick(); tick();
    cur = "R2"; do_req(0, 0, 8, 1, 64'h1234_5678_9ABC_DEF0); tick();
    cur = "R7"; do_req(0, 2, 3, 2, PAT); tick();
    cur = "R10"; do_ub(2, 0, 0, 0); tick();
    cur = "R10"; do_ub(0, 0, 1, 0); tick(); do_ub(0, 2, 1, 0); tick();
    cur = "R2"; do_req(1, 0, 8, 2, 64'hFEDC_BA98_7654_3210); tick();
    cur = "R10"; do_ub(2, 1, 1, 0); tick();
    cur = "R3"; do_req(2, 0, 1, 3, PAT); tick();
    cur = "R8"; do_req(3, 4, 2, 4, PAT); tick();
    cur = "R9"; do_mem(1, 2, 0); tick();
    cur = "R4"; do_mem(0, 2, FETCH); tick();
    chk(mem_req_data == 64'hAAAA_AAAA_AAAA_AA77, "first byte merge", mem_req_data, 64'hAAAA_AAAA_AAAA_AA77);
    cur = "R10"; do_ub(2, 0, 2, 0); tick();
    cur = "R10"; do_ub(0, 1, 3, 0); tick();
    cur = "R3"; do_req(3, 3, 2, 5, PAT); tick();
    cur = "R4"; do_mem(0, 3, FETCH); tick();
    chk(mem_req_data == 64'hAAAA_AA33_44AA_AAAA, "middle merge", mem_req_data, 64'hAAAA_AA33_44AA_AAAA);
    cur = "R10"; do_ub(2, 0, 3, 0); tick();
    cur = "R3"; do_req(2, 7, 1, 6, PAT); tick();
    cur = "R4"; do_mem(0, 2, FETCH); tick();
    chk(mem_req_data == 64'h00AA_AAAA_AAAA_AAAA, "last byte merge", mem_req_data, 64'h00AA_AAAA_AAAA_AAAA);
    cur = "R10"; do_ub(2, 0, 2, 0); tick();
    cur = "R10"; do_ub(1, 3, 0, 0); tick();
    cur = "R5"; do_req(0, 0, 8, 7, 64'h5555_6666_7777_8888); tick();
    cur = "R6"; do_ub(3, 3, 0, FETCH); tick();
    cur = "R10"; do_ub(2, 0, 0, 0); tick();
    cur = "R10"; do_ub(1, 1, 1, 0); tick(); do_ub(0, 0, 1, 0); tick();
    cur = "R5"; do_req(1, 2, 3, 8, PAT); tick();
    cur = "R8"; do_req(2, 1, 2, 9, PAT); tick();
    cur = "R6"; do_ub(3, 1, 1, FETCH); tick();
    cur = "R11"; do_req(2, 0, 8, 10, PAT); do_ub(2, 0, 1, 0); tick();
    cur = "R11"; do_req(2, 0, 8, 11, PAT); do_mem(1, 0, 0); tick();
    cur = "R2"; do_req(2, 0, 8, 12, PAT); tick();
    cur = "R1"; tick();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule